// File: doc/BRIEF.md
# SMBus Indexed Register Slave

This block is a target-only SMBus endpoint that holds a small control register file for a clock distribution path. A host addresses it with a fixed 7-bit address and then moves one or more bytes in a single transfer. A transfer names a starting register and then a byte count. The register contents are always present on a parallel output bus, so the clock control logic next to it sees every change as soon as it is written.

SCL and SDA arrive as plain inputs and are resynchronised inside the block. SDA is driven through an open-drain output enable: when `sda_oe` is 1 the pad pulls the line low. The block never stretches the clock and has no packet error checking.

A write carries an offset, a non-zero count and that many data bytes. A read sets the offset with a write header, then uses a repeated start with the read address. The slave returns the number of registers left from the offset, then the register bytes from the offset upward, until the host answers a byte with NACK.

Top module: `smbus_regblock_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1101110 (0xDC for write, 0xDD for read). Any other address is not acknowledged, and the rest of that transfer is ignored.
- R2: A write of the form address(W), offset, count N, then N data bytes has every byte acknowledged. Data byte k is stored in register offset+k.
- R3: A write with count 0 has its count byte NACKed. The transfer is abandoned, and no register changes.
- R4: Data bytes beyond the count N are NACKed and not stored.
- R5: After reset, register 0 is 0x07, register 1 is 0x66, register 2 is 0x00 and register 3 is 0x00. `ctrl_regs` carries register k in bits 8k+7:8k, and SDA is released.
- R6: Only these bits take written values: bits 0, 1, 2, 6 and 7 of register 0; bits 1, 2, 5 and 6 of registers 1 and 2; all bits of register 3. Every other bit reads 0.
- R7: Register 4 always reads 0x20, and writes to it are ignored. Offsets above 4 read as 0x00, and writes to them are ignored.
- R8: After a read address is acknowledged, the slave sends a count byte equal to 5 minus the offset (0 when the offset is above 4). It then sends register bytes from the offset upward, most significant bit first.
- R9: A NACK from the host after a read byte ends the data phase. The slave drives SDA no more until the next start.
- R10: A start, including a repeated start, or a stop at any point sends the slave back to waiting for an address. The register pointer is kept.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SMBus clock line level |
| sda_in | input | 1 | SMBus data line level (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ctrl_regs | output | 32 | Read/write registers 0 to 3, register k in bits 8k+7:8k |

## Verification
The hardest state to reach from the pins is a transfer abandoned part way. Examples are a count of zero, bytes sent past the count, a host NACK followed by more clocks, and a repeated start issued in the middle of a write. Each one needs a host that keeps toggling the bus after the slave has stopped acknowledging. The bench's bit-level host model does exactly that: it sends each byte regardless of the acknowledge it got. It then reads the registers back through a fresh transfer, or watches the bus floating high, to show that nothing was stored and nothing was driven.

// File: rtl/smbslv_pkg.sv
package smbslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } eng_state_e;

  typedef enum logic [1:0] {
    RB_ADDR,
    RB_OFFSET,
    RB_COUNT,
    RB_DATA
  } rx_role_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/smbslv_linemon.sv
module smbslv_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_now, sda_now;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] scl_p, sda_p;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[SYNC_STAGES-2:0], scl_in};
          sda_p <= {sda_p[SYNC_STAGES-2:0], sda_in};
        end
      end
      assign scl_now = scl_p[SYNC_STAGES-1];
      assign sda_now = sda_p[SYNC_STAGES-1];
    end else begin : g_single
      logic scl_p, sda_p;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= 1'b1;
          sda_p <= 1'b1;
        end else begin
          scl_p <= scl_in;
          sda_p <= sda_in;
        end
      end
      assign scl_now = scl_p;
      assign sda_now = sda_p;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_evt <= 1'b0;
      stop_evt  <= 1'b0;
    end else begin
      scl_d     <= scl_now;
      sda_d     <= sda_now;
      sda_lvl   <= sda_now;
      scl_rise  <= scl_now & ~scl_d;
      scl_fall  <= ~scl_now & scl_d;
      start_evt <= scl_now & scl_d & sda_d & ~sda_now;
      stop_evt  <= scl_now & scl_d & ~sda_d & sda_now;
    end
  end

endmodule

// File: rtl/smbslv_regfile.sv
module smbslv_regfile #(
  parameter int                  NUM_RW   = 4,
  parameter logic [7:0]          ID_VALUE = 8'h20,
  parameter logic [NUM_RW*8-1:0] RW_RESET = '0,
  parameter logic [NUM_RW*8-1:0] RW_MASK  = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_RW*8-1:0]   regs_flat
);

  logic [7:0] rf [NUM_RW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_RW; k++) rf[k] <= RW_RESET[k*8 +: 8];
    end else begin
      for (int k = 0; k < NUM_RW; k++) begin
        if (wr_en && wr_addr == 8'(k)) rf[k] <= wr_data & RW_MASK[k*8 +: 8];
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_RW; g++) begin : g_flat
      assign regs_flat[g*8 +: 8] = rf[g];
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_RW; k++) begin
      if (rd_addr == 8'(k)) rd_data = rf[k];
    end
    if (rd_addr == 8'(NUM_RW)) rd_data = ID_VALUE;
  end

endmodule

// File: rtl/smbslv_engine.sv
module smbslv_engine
  import smbslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int         NUM_REGS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_lvl,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output eng_state_e st,
  output rx_role_e   role
);

  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [7:0]        remain;
  logic              rd_mode;
  logic [7:0]        cnt_byte;

  always_comb begin
    cnt_byte = (ptr < 8'(NUM_REGS)) ? 8'(NUM_REGS) - ptr : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      role    <= RB_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      remain  <= '0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st     <= ST_RX;
        role   <= RB_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (role)
                RB_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd_mode <= shreg[0];
                    role    <= RB_OFFSET;
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                RB_OFFSET: begin
                  ptr    <= shreg;
                  role   <= RB_COUNT;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                RB_COUNT: begin
                  if (shreg == 8'h00) begin
                    st <= ST_SKIP;
                  end else begin
                    remain <= shreg;
                    role   <= RB_DATA;
                    sda_oe <= 1'b1;
                    st     <= ST_RX_ACK;
                  end
                end
                default: begin
                  if (remain != 8'h00) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= shreg;
                    ptr     <= ptr + 8'd1;
                    remain  <= remain - 8'd1;
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                shreg  <= cnt_byte;
                sda_oe <= ~cnt_byte[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && sda_lvl) begin
              st <= ST_SKIP;
            end else if (scl_fall) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 8'd1;
              bitcnt <= '0;
              st     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smbus_regblock_slave.sv
module smbus_regblock_slave
  import smbslv_pkg::*;
#(
  parameter logic [6:0]                   DEV_ADDR    = 7'h6E,
  parameter int                           NUM_REGS    = 5,
  parameter int                           SYNC_STAGES = 2,
  parameter logic [7:0]                   ID_VALUE    = 8'h20,
  parameter logic [8*(NUM_REGS-1)-1:0]    RW_RESET    = {8'h00, 8'h00, 8'h66, 8'h07},
  parameter logic [8*(NUM_REGS-1)-1:0]    RW_MASK     = {8'hFF, 8'h66, 8'h66, 8'hC7}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_in,
  input  logic                         sda_in,
  output logic                         sda_oe,
  output logic [8*(NUM_REGS-1)-1:0]    ctrl_regs
);

  localparam int NUM_RW = NUM_REGS - 1;

  logic       sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, ptr, rd_data;
  eng_state_e eng_st;
  rx_role_e   eng_role;

  smbslv_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smbslv_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ptr(ptr), .st(eng_st), .role(eng_role)
  );

  smbslv_regfile #(
    .NUM_RW(NUM_RW), .ID_VALUE(ID_VALUE), .RW_RESET(RW_RESET), .RW_MASK(RW_MASK)
  ) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .regs_flat(ctrl_regs)
  );

endmodule

// File: rtl/smbslv_checker.sv
module smbslv_checker
  import smbslv_pkg::*;
#(
  parameter int                  NUM_RW  = 4,
  parameter logic [NUM_RW*8-1:0] RW_MASK = '1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_in,
  input logic                  sda_oe,
  input logic                  start_evt,
  input eng_state_e            st,
  input rx_role_e              role,
  input logic [NUM_RW*8-1:0]   ctrl_regs
);

  // R11
  sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_in));

  // R9
  skip_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_oe);

  // R10
  start_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (st == ST_RX && role == RB_ADDR));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_regs & ~RW_MASK) == '0);

endmodule

bind smbus_regblock_slave smbslv_checker #(.NUM_RW(NUM_RW), .RW_MASK(RW_MASK)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe), .start_evt(start_evt),
  .st(eng_st), .role(eng_role), .ctrl_regs(ctrl_regs)
);

// File: tb/smbus_regblock_slave_test.sv
`timescale 1ns/1ps
module smbus_regblock_slave_test;

  localparam int HP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [31:0] ctrl_regs;
  int          checks = 0;
  int          failures = 0;
  int          viol = 0;
  logic        oe_q = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  smbus_regblock_slave uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .ctrl_regs(ctrl_regs)
  );

  // R11 monitor: SDA drive must not move while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_q && scl_m) viol++;
    oe_q = sda_oe;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(HP/2);
    scl_m = 1'b1; wait_cyc(HP);
    sda_m = 1'b0; wait_cyc(HP);
    scl_m = 1'b0; wait_cyc(HP/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(HP/2);
    scl_m = 1'b1; wait_cyc(HP);
    sda_m = 1'b1; wait_cyc(HP);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wait_cyc(HP/2);
    scl_m = 1'b1; wait_cyc(HP);
    r = sda_line;
    scl_m = 1'b0; wait_cyc(HP/2);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(last, r);
  endtask

  task automatic wr_block(input logic [7:0] off, input logic [7:0] cnt, input int nsend,
                          input logic [31:0] data, output logic [7:0] acks);
    acks = '0;
    bus_start();
    put_byte(8'hDC, acks[0]);
    put_byte(off, acks[1]);
    put_byte(cnt, acks[2]);
    for (int i = 0; i < nsend; i++) put_byte(data[i*8 +: 8], acks[3+i]);
    bus_stop();
  endtask

  task automatic rd_block(input logic [7:0] off, input int n, output logic [7:0] cnt,
                          output logic [39:0] data, output logic [2:0] acks);
    data = '0;
    bus_start();
    put_byte(8'hDC, acks[0]);
    put_byte(off, acks[1]);
    bus_start();
    put_byte(8'hDD, acks[2]);
    get_byte(n == 0, cnt);
    for (int i = 0; i < n; i++) get_byte(i == n-1, data[i*8 +: 8]);
    bus_stop();
  endtask

  // {offset, written value, expected readback}
  localparam logic [23:0] VEC [8] = '{
    24'h00_FF_C7, 24'h01_FF_66, 24'h02_FF_66, 24'h03_A5_A5,
    24'h04_55_20, 24'h00_00_00, 24'h01_99_00, 24'h02_42_42
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0]  acks, cnt, d;
    logic [2:0]  racks;
    logic [39:0] data;
    logic        a;

    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);

    check("R5 reset ctrl_regs", ctrl_regs, 32'h0000_6607);
    check("R5 reset sda released", sda_oe, 0);

    rd_block(8'd0, 5, cnt, data, racks);
    check("R1 read header acks", racks, 3'b111);
    check("R8 count from offset 0", cnt, 8'd5);
    check("R5 R7 reset block read", data, 40'h20_00_00_66_07);

    for (int v = 0; v < 8; v++) begin
      logic [7:0] off, wv, ev;
      off = VEC[v][23:16];
      wv  = VEC[v][15:8];
      ev  = VEC[v][7:0];
      wr_block(off, 8'd1, 1, {24'h0, wv}, acks);
      check("R2 single write acks", acks, 8'h0F);
      rd_block(off, 1, cnt, data, racks);
      check("R8 count byte", cnt, 8'd5 - off);
      check("R6 R7 readback", data[7:0], ev);
      if (off < 4) check("R6 ctrl_regs byte", ctrl_regs[off*8 +: 8], ev);
    end

    // R1: foreign address ignored
    bus_start();
    put_byte(8'hDE, a);
    check("R1 foreign address NACK", a, 0);
    put_byte(8'h00, a);
    check("R1 following byte ignored", a, 0);
    bus_stop();
    check("R1 no register change", ctrl_regs, 32'hA542_0000);

    // R3: zero count
    wr_block(8'd3, 8'd0, 1, 32'h11, acks);
    check("R3 zero count NACK", acks, 8'h03);
    check("R3 registers untouched", ctrl_regs, 32'hA542_0000);

    // R4: surplus byte
    wr_block(8'd2, 8'd1, 2, 32'h0000_773C, acks);
    check("R4 surplus byte NACK", acks, 8'h0F);
    check("R4 surplus byte not stored", ctrl_regs, 32'hA524_0000);

    // R2: multi-byte write
    wr_block(8'd0, 8'd4, 4, 32'h1224_6681, acks);
    check("R2 block write acks", acks, 8'h7F);
    check("R2 block write data", ctrl_regs, 32'h1224_6681);
    rd_block(8'd1, 3, cnt, data, racks);
    check("R8 count from offset 1", cnt, 8'd4);
    check("R8 ordered block read", data[23:0], 24'h12_24_66);

    // R7: id byte and out-of-range offsets
    rd_block(8'd4, 1, cnt, data, racks);
    check("R7 id count", cnt, 8'd1);
    check("R7 id value", data[7:0], 8'h20);
    rd_block(8'd6, 1, cnt, data, racks);
    check("R7 out-of-range count", cnt, 8'd0);
    check("R7 out-of-range data", data[7:0], 8'h00);
    wr_block(8'd6, 8'd1, 1, 32'hFF, acks);
    check("R7 out-of-range write harmless", ctrl_regs, 32'h1224_6681);

    // R9: host NACK ends data phase
    bus_start();
    put_byte(8'hDC, a);
    put_byte(8'h00, a);
    bus_start();
    put_byte(8'hDD, a);
    get_byte(1'b0, cnt);
    get_byte(1'b1, d);
    check("R9 first byte before NACK", d, 8'h81);
    get_byte(1'b1, d);
    check("R9 bus floats after NACK", d, 8'hFF);
    bus_stop();
    check("R9 sda released", sda_oe, 0);

    // R10: repeated start mid-write, stop mid-transfer
    bus_start();
    put_byte(8'hDC, a);
    put_byte(8'h01, a);
    put_byte(8'h02, a);
    put_byte(8'h00, a);
    bus_start();
    put_byte(8'hDC, a);
    check("R10 address after repeated start", a, 1);
    put_byte(8'h03, a);
    put_byte(8'h01, a);
    put_byte(8'h5A, a);
    bus_stop();
    check("R10 partial write then new write", ctrl_regs, 32'h5A24_0081);
    bus_start();
    put_byte(8'hDC, a);
    bus_stop();
    rd_block(8'd2, 1, cnt, data, racks);
    check("R10 transfer after early stop", {cnt, data[7:0]}, 16'h0324);

    check("R11 sda changes only with scl low", viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule